// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small group of external interrupt pins and turns qualifying activity on them into a single interrupt request for a processor. Each pin is first brought into the clock domain by a two-stage synchroniser. A two-bit sense code per pin then selects what counts as an event: the pin sitting low, any change of level, a high-to-low transition, or a low-to-high transition.

Software programs the sense codes and a per-pin enable mask through a byte-wide register bus. It reads and clears per-pin pending flags through the same bus. The request output is raised while any pending flag has its mask bit set. An index output names the lowest-numbered such pin. The processor returns a one-cycle acknowledge when it services the request. In the edge and change modes, the acknowledge clears the named pin's flag.

In the low-level mode the flag is not a latch: it tracks the pin. Neither a software clear nor an acknowledge removes it while the pin stays low. It drops only once the synchronised pin is seen high again.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the sense register, the mask register and all flags are 0, and `irq_req` is low.
- R2: The register map is as follows. Address 0 holds the sense register, with pin i's code at bits 2i+1:2i. Address 1 holds the mask register, with pin i at bit i. Address 2 holds the flags, with pin i at bit i. Address 3 reads as 0. All bits of the sense and mask bytes read back as written. A read strobe (`bus_sel`=1, `bus_we`=0) returns its data on `bus_rdata` after the next clock edge.
- R3: Sense code 0 selects the low-level mode. Code 1 selects any change. Code 2 selects a falling transition and code 3 a rising transition. In rising mode a falling transition never sets the flag, and in falling mode a rising transition never sets it.
- R4: An event sets a pin's flag only if that pin's mask bit is 1 when the event is detected. Setting the mask bit later does not create a flag from an earlier event.
- R5: In the edge and change modes, writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it unchanged.
- R6: In the edge and change modes, `irq_ack` clears the flag of the pin named by `irq_idx`, provided it is sampled while `irq_req` is high.
- R7: In low-level mode, a masked pin held low sets its flag. A flag-clear write and an acknowledge both leave that flag set while the pin is low. The flag clears once the pin is seen high.
- R8: `irq_req` is high exactly when some pin has both its flag and its mask bit set. `irq_idx` is the lowest such pin. Clearing a mask bit lowers the request but leaves the flag readable as set.
- R9: A pin change applied just after a clock edge shows up in the flag and in `irq_req` after the third following clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pins_in | input | NUM_PINS | Asynchronous external interrupt pins |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | IDX_W | Lowest pending, enabled pin |
| irq_ack | input | 1 | One-cycle service acknowledge |

## Verification
On every cycle, the assertions check the following per-pin flag rules:
- the low-level flag sets while the pin is low and the pin is enabled;
- the low-level flag stays set through clears while the pin is low;
- the low-level flag drops on a high pin;
- no flag rises while the pin is masked;
- a falling transition never sets a rising-mode flag.

The assertions also check that the request and index agree with the flags and mask. The bench alone can show other behaviour: the exact three-edge latency through the synchroniser, the register read-back layout, that a zero written to a flag changes nothing, and the lowest-index choice across an acknowledge. Long random runs of pin toggles, writes and acknowledges are compared against a reference model built from the requirements.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_ANY  = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_e;

  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_MASK  = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/ext_irq_pin_cell.sv
module ext_irq_pin_cell
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  sense_e sense,
  input  logic   enable,
  input  logic   clr_sw,
  input  logic   clr_ack,
  output logic   flag_q,
  output logic   flag_d
);
  logic prev_q;
  logic rise, fall, evt;

  always_comb begin
    rise = pin_s & ~prev_q;
    fall = ~pin_s & prev_q;
    unique case (sense)
      SENSE_ANY:  evt = rise | fall;
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
    if (sense == SENSE_LOW) begin
      if (!pin_s && enable) flag_d = 1'b1;
      else if (pin_s)       flag_d = 1'b0;
      else                  flag_d = flag_q;
    end else begin
      flag_d = (evt & enable) | (flag_q & ~(clr_sw | clr_ack));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assert_level_set_R7: assert property (@(posedge clk) disable iff (rst)
    (sense == SENSE_LOW && !pin_s && enable) |=> flag_q);
  assert_level_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (sense == SENSE_LOW && !pin_s && flag_q) |=> flag_q);
  assert_level_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sense == SENSE_LOW && pin_s) |=> !flag_q);
  assert_masked_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!enable && !flag_q) |=> !flag_q);
  assert_rise_ignores_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (sense == SENSE_RISE && prev_q && !pin_s && !flag_q) |=> !flag_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_idx,
  input  logic              irq_ack
);
  localparam int SENSE_W = 2 * NUM_PINS;

  logic [DATA_W-1:0]   sense_q, mask_q, mask_nxt;
  logic [NUM_PINS-1:0] pins_s, flag_q, flag_d, w1c, ack_hit, pend_nxt;
  logic [IDX_W-1:0]    idx_nxt;
  logic                wr_en, rd_en;

  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  ext_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pins_in), .sync_out(pins_s)
  );

  always_comb begin
    w1c      = (wr_en && bus_addr == ADDR_FLAG) ? bus_wdata[NUM_PINS-1:0] : '0;
    mask_nxt = (wr_en && bus_addr == ADDR_MASK) ? bus_wdata : mask_q;
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    assign ack_hit[gi] = irq_ack & irq_req & (irq_idx == IDX_W'(gi));
    ext_irq_pin_cell u_cell (
      .clk(clk), .rst(rst), .pin_s(pins_s[gi]),
      .sense(sense_e'(sense_q[2*gi +: 2])), .enable(mask_q[gi]),
      .clr_sw(w1c[gi]), .clr_ack(ack_hit[gi]),
      .flag_q(flag_q[gi]), .flag_d(flag_d[gi])
    );
  end

  always_comb begin
    pend_nxt = flag_d & mask_nxt[NUM_PINS-1:0];
    idx_nxt  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pend_nxt[i]) idx_nxt = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q   <= '0;
      mask_q    <= '0;
      bus_rdata <= '0;
      irq_req   <= 1'b0;
      irq_idx   <= '0;
    end else begin
      if (wr_en && bus_addr == ADDR_SENSE) sense_q <= bus_wdata;
      mask_q  <= mask_nxt;
      irq_req <= |pend_nxt;
      irq_idx <= idx_nxt;
      if (rd_en) begin
        unique case (bus_addr)
          ADDR_SENSE: bus_rdata <= sense_q;
          ADDR_MASK:  bus_rdata <= mask_q;
          ADDR_FLAG:  bus_rdata <= DATA_W'(flag_q);
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  assert_req_has_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (flag_q[irq_idx] && mask_q[irq_idx]));
  assert_no_req_no_source_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> ((flag_q & mask_q[NUM_PINS-1:0]) == '0));
  assert_sense_width_R2: assert property (@(posedge clk) disable iff (rst)
    SENSE_W <= DATA_W);
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 2;
  localparam int DW = 8;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0, irq_ack = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] pins = 0;
  logic irq_req;
  logic [0:0] irq_idx;

  int checks = 0, fails = 0;
  bit model_on = 0, finished = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins), .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack)
  );

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_flag;
  logic [DW-1:0] m_sense, m_mask, m_rdata;
  logic m_irq, m_idx, m_rd_pend;

  function automatic logic [N-1:0] ref_flags(logic [N-1:0] f, logic [N-1:0] cur,
      logic [N-1:0] prv, logic [DW-1:0] sen, logic [DW-1:0] msk,
      logic [N-1:0] clr);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic [1:0] c;
      logic ev;
      c = sen[2*i +: 2];
      ev = (c == 2'd1) ? (cur[i] != prv[i]) :
           (c == 2'd2) ? (!cur[i] && prv[i]) :
           (c == 2'd3) ? (cur[i] && !prv[i]) : 1'b0;
      if (c == 2'd0) r[i] = (!cur[i] && msk[i]) ? 1'b1 : (cur[i] ? 1'b0 : f[i]);
      else r[i] = (ev && msk[i]) | (f[i] & ~clr[i]);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_sense = 0; m_mask = 0;
      m_rdata = 0; m_irq = 0; m_idx = 0; m_rd_pend = 0;
    end else begin
      logic [N-1:0] clr;
      clr = 0;
      if (bus_sel && bus_we && bus_addr == 2) clr = bus_wdata[N-1:0];
      if (irq_ack && m_irq) clr[m_idx] = 1'b1;
      m_rd_pend = bus_sel && !bus_we;
      if (m_rd_pend)
        m_rdata = (bus_addr == 0) ? m_sense : (bus_addr == 1) ? m_mask :
                  (bus_addr == 2) ? DW'(m_flag) : '0;
      m_flag = ref_flags(m_flag, m_s2, m_prev, m_sense, m_mask, clr);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
      if (bus_sel && bus_we && bus_addr == 0) m_sense = bus_wdata;
      if (bus_sel && bus_we && bus_addr == 1) m_mask = bus_wdata;
      m_irq = |(m_flag & m_mask[N-1:0]);
      m_idx = (m_flag[0] && m_mask[0]) ? 1'b0 : 1'b1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    cyc(1);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic ack();
    irq_ack = 1; cyc(1); irq_ack = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  // random-phase comparison against the model
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R8 irq_req", irq_req, m_irq);
      if (m_irq) chk("R8 irq_idx", irq_idx, m_idx);
      if (m_rd_pend) chk("R2 rdata", bus_rdata, m_rdata);
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 irq", irq_req, 0);
    rd(0, d); chk("R1 sense", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(2, d); chk("R1 flag", d, 0);

    wr(0, 8'h5A); rd(0, d); chk("R2 sense readback", d, 8'h5A);
    wr(1, 8'hC0); rd(1, d); chk("R2 mask readback", d, 8'hC0);
    rd(3, d); chk("R2 addr3", d, 0);

    // pin0 rising, pin1 falling
    wr(0, 8'h0B); wr(1, 8'h03);
    pins[0] = 1; cyc(2);
    chk("R9 not after two edges", irq_req, 0);
    cyc(1);
    chk("R9 after three edges", irq_req, 1);
    chk("R3 rise idx", irq_idx, 0);
    rd(2, d); chk("R3 rise flag", d, 8'h01);
    ack(); chk("R6 ack irq", irq_req, 0);
    rd(2, d); chk("R6 ack flag", d, 0);
    pins[0] = 0; cyc(4);
    rd(2, d); chk("R3 rise ignores fall", d, 0);

    wr(1, 8'h02); pins[0] = 1; cyc(4);
    rd(2, d); chk("R4 masked event", d, 0);
    wr(1, 8'h03); cyc(2);
    rd(2, d); chk("R4 late unmask", d, 0);

    pins[1] = 1; cyc(4);
    rd(2, d); chk("R3 fall ignores rise", d, 0);
    pins[1] = 0; cyc(4);
    chk("R3 fall irq", irq_req, 1); chk("R8 idx pin1", irq_idx, 1);
    pins[0] = 0; cyc(4); pins[0] = 1; cyc(4);
    rd(2, d); chk("R8 both flags", d, 8'h03);
    chk("R8 lowest idx", irq_idx, 0);
    ack(); cyc(1);
    rd(2, d); chk("R6 ack clears only idx", d, 8'h02);
    chk("R8 idx after ack", irq_idx, 1);
    wr(2, 8'h00); rd(2, d); chk("R5 write zero", d, 8'h02);
    wr(1, 8'h01); cyc(1);
    chk("R8 mask drops req", irq_req, 0);
    rd(2, d); chk("R8 flag kept", d, 8'h02);
    wr(2, 8'h02); rd(2, d); chk("R5 w1c", d, 0);
    wr(1, 8'h03);

    // any change on pin0
    wr(0, 8'h09);
    pins[0] = 0; cyc(4);
    rd(2, d); chk("R3 any fall", d, 8'h01);
    wr(2, 8'h01); rd(2, d); chk("R5 any clear", d, 0);
    pins[0] = 1; cyc(4);
    rd(2, d); chk("R3 any rise", d, 8'h01);
    wr(2, 8'h01);

    // low level on pin0
    wr(0, 8'h08); cyc(2);
    rd(2, d); chk("R7 high no flag", d, 0);
    pins[0] = 0; cyc(4);
    chk("R7 level irq", irq_req, 1);
    wr(2, 8'h01); rd(2, d); chk("R7 w1c ignored", d, 8'h01);
    ack(); rd(2, d); chk("R7 ack ignored", d, 8'h01);
    pins[0] = 1; cyc(3);
    chk("R7 release irq", irq_req, 0);
    rd(2, d); chk("R7 release flag", d, 0);

    // random phase
    model_on = 1;
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) pins = N'($urandom);
      bus_sel = 0; bus_we = 0; irq_ack = 0;
      if (r >= 20 && r < 30) begin
        bus_sel = 1; bus_we = 1; bus_addr = 2'($urandom_range(0, 2));
        bus_wdata = 8'($urandom);
      end else if (r >= 30 && r < 45) begin
        bus_sel = 1; bus_we = 0; bus_addr = 2'($urandom);
      end else if (r >= 45 && r < 60 && irq_req) begin
        irq_ack = 1;
      end
      cyc(1);
    end
    bus_sel = 0; bus_we = 0; irq_ack = 0;
    cyc(2);
    model_on = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule